// File: doc/BRIEF.md
# I2C DAC Command Decoder

This block is the target-side command parser of a single-channel 12-bit DAC. A front end filters the pins and detects conditions. It delivers bus events to this block: a start or repeated start, a stop, and one strobe per SCL high phase carrying the sampled SDA level. The parser matches the control byte against its own address or the general call address. It decodes the command bytes that follow and updates the volatile DAC code and the two power-down bits. During acknowledge slots and read data slots it tells the front end when to pull SDA low.

A write frame is two bytes. The two top bits of the first byte select the operation. Frames may repeat back to back under one control byte, and every completed frame is applied. A read streams a status byte and the two DAC bytes in a loop until the master answers with a not-acknowledge. Every register change is published as a one-cycle strobe. The new code and power-down bits change on the same edge, so the analog model downstream can latch them together.

States: `ST_IDLE` (waiting for a start), `ST_ADDR` / `ST_ADDR_ACK` (control byte and its acknowledge), `ST_CMD_HI` / `ST_HI_ACK` and `ST_CMD_LO` / `ST_LO_ACK` (the two bytes of a write frame), `ST_GC_CMD` / `ST_GC_ACK` (general call command byte), `ST_RD_BYTE` / `ST_RD_ACK` (read byte and master acknowledge), and `ST_IGNORE` (bus ignored until the next start).

Transitions:
- A start goes to `ST_ADDR` from any state, and a stop goes to `ST_IDLE` from any state. Both take priority over a bit strobe in the same cycle.
- On the eighth bit strobe, each byte state moves to its acknowledge state.
- From `ST_ADDR_ACK`, the next strobe moves the parser as follows:
  - own address with read: `ST_RD_BYTE`
  - own address with write: `ST_CMD_HI`
  - general call: `ST_GC_CMD`
  - anything else: `ST_IGNORE`
- `ST_HI_ACK` goes to `ST_CMD_LO`.
- `ST_LO_ACK` goes back to `ST_CMD_HI`, which is how continuous frames work.
- `ST_GC_ACK` goes to `ST_IGNORE`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on an acknowledge, or to `ST_IGNORE` on a not-acknowledge.

Top module: `i2cdac_top`

## Requirements
- R1: During reset `sda_pull`, `upd_stb`, `dac_code` and `pd_bits` are all zero.
- R2: A control byte whose upper seven bits equal `DEV_ADDR` is acknowledged (`sda_pull` high in its ninth slot) for either R/W value. Any other control byte except the general call address (0x00) is not acknowledged, and later bytes get neither acknowledge nor update until a new start.
- R3: A write frame is two bytes with every byte acknowledged. Byte one is {C2, C1, PD1, PD0, D11..D8} and byte two is D7..D0. When C2:C1 = 00 (C0 position ignored), the frame loads `dac_code` = D11..D0 and `pd_bits` = PD1:PD0. This happens on the edge after the ninth-slot strobe of byte two, with `upd_stb` high for exactly that one cycle.
- R4: Further two-byte frames sent without a stop are each decoded and applied as new commands.
- R5: A start or stop arriving before the ninth-slot strobe of byte two discards the frame with no register change.
- R6: Frames with C2:C1 other than 00 are acknowledged but change nothing and raise no strobe.
- R7: With R/W = 1 the block returns the status byte {ready, 5'b0, PD1, PD0}, where ready = !`nv_busy`, then {4'b0, D11..D8}, then D7..D0. The sequence repeats while the master acknowledges, and a master not-acknowledge releases SDA for the rest of the transaction.
- R8: General call byte 0x06 clears the code and the PD bits, and 0x09 clears only the PD bits. Both are acknowledged and strobed. Any other general call byte is not acknowledged and changes nothing.
- R9: A write frame is accepted and applied while `nv_busy` is high.
- R10: `dac_code` and `pd_bits` change only on an edge that also raises `upd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | One-cycle pulse: start or repeated start seen |
| ev_stop | input | 1 | One-cycle pulse: stop seen |
| bit_stb | input | 1 | One-cycle pulse per SCL high phase |
| bit_din | input | 1 | SDA level sampled with `bit_stb` |
| nv_busy | input | 1 | Nonvolatile programming in progress |
| sda_pull | output | 1 | Drive SDA low in the current slot |
| upd_stb | output | 1 | One-cycle register update strobe |
| dac_code | output | 12 | Current volatile DAC code |
| pd_bits | output | 2 | Current volatile power-down bits |

## Verification
A parser that has lost its place in the byte shows up at the next ninth slot, at most eight strobes later. It either fails to pull SDA or pulls it where the master is driving data. A wrong read index or stale register shows up as a wrong serialized bit within one read byte. A lost or spurious update appears as an `upd_stb` pulse with no pending expectation, or as a missing pulse. This is visible one cycle after the ninth-slot strobe of the frame's second byte.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
    localparam int DAC_W   = 12;
    localparam int PD_W    = 2;
    localparam int HI_W    = DAC_W - 8;
    localparam int RD_NUM  = 3;
    localparam logic [7:0] GC_ADDR  = 8'h00;
    localparam logic [7:0] GC_RESET = 8'h06;
    localparam logic [7:0] GC_WAKE  = 8'h09;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD_HI,
        ST_HI_ACK,
        ST_CMD_LO,
        ST_LO_ACK,
        ST_GC_CMD,
        ST_GC_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } state_e;
endpackage

// File: rtl/i2cdac_rx_shift.sv
module i2cdac_rx_shift #(
    parameter int BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         shift_en,
    input  logic                         din,
    output logic [BITS-1:0]              data_q,
    output logic [$clog2(BITS+1)-1:0]    cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            data_q <= {data_q[BITS-2:0], din};
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2cdac_regs.sv
module i2cdac_regs #(
    parameter int DAC_W = 12,
    parameter int PD_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [DAC_W-1:0] ld_dac,
    input  logic [PD_W-1:0]  ld_pd,
    output logic [DAC_W-1:0] dac_q,
    output logic [PD_W-1:0]  pd_q,
    output logic             stb_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q <= '0;
            pd_q  <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= ld_en;
            if (ld_en) begin
                dac_q <= ld_dac;
                pd_q  <= ld_pd;
            end
        end
    end
endmodule

// File: rtl/i2cdac_tx_sel.sv
module i2cdac_tx_sel
    import i2cdac_pkg::*;
(
    input  logic [1:0]       idx,
    input  logic             ready,
    input  logic [PD_W-1:0]  pd,
    input  logic [DAC_W-1:0] dac,
    input  logic [2:0]       bit_pos,
    output logic             tx_bit
);
    logic [7:0] tx_byte;

    always_comb begin
        unique case (idx)
            2'd0:    tx_byte = {ready, {(7-PD_W){1'b0}}, pd};
            2'd1:    tx_byte = {{(8-HI_W){1'b0}}, dac[DAC_W-1:8]};
            default: tx_byte = dac[7:0];
        endcase
        tx_bit = tx_byte[bit_pos];
    end
endmodule

// File: rtl/i2cdac_top.sv
module i2cdac_top
    import i2cdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             bit_stb,
    input  logic             bit_din,
    input  logic             nv_busy,
    output logic             sda_pull,
    output logic             upd_stb,
    output logic [11:0]      dac_code,
    output logic [1:0]       pd_bits
);
    localparam int CNT_W = $clog2(9);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);
    localparam logic [1:0] RD_LAST = 2'(RD_NUM - 1);

    state_e             state_q, state_d;
    logic [7:0]         rx_byte;
    logic [CNT_W-1:0]   rx_cnt;
    logic [7:0]         hi_q;
    logic [1:0]         rd_idx_q;
    logic               evt, last_bit, addr_hit, gc_hit, gc_known, tx_bit;
    logic               shift_en, clr, ld_en;
    logic [DAC_W-1:0]   ld_dac;
    logic [PD_W-1:0]    ld_pd;
    logic               ack_stb;

    assign evt      = ev_start | ev_stop;
    assign last_bit = (rx_cnt == LAST_BIT);
    assign addr_hit = (rx_byte[7:1] == DEV_ADDR);
    assign gc_hit   = (rx_byte == GC_ADDR);
    assign gc_known = (rx_byte == GC_RESET) || (rx_byte == GC_WAKE);
    assign ack_stb  = bit_stb && !evt;

    i2cdac_rx_shift #(.BITS(8)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (shift_en),
        .din      (bit_din),
        .data_q   (rx_byte),
        .cnt_q    (rx_cnt)
    );

    i2cdac_tx_sel u_tx (
        .idx     (rd_idx_q),
        .ready   (!nv_busy),
        .pd      (pd_bits),
        .dac     (dac_code),
        .bit_pos (3'd7 - rx_cnt[2:0]),
        .tx_bit  (tx_bit)
    );

    i2cdac_regs #(.DAC_W(DAC_W), .PD_W(PD_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_dac (ld_dac),
        .ld_pd  (ld_pd),
        .dac_q  (dac_code),
        .pd_q   (pd_bits),
        .stb_q  (upd_stb)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame holding and read index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q     <= '0;
            rd_idx_q <= '0;
        end else if (ack_stb) begin
            if (state_q == ST_HI_ACK)   hi_q <= rx_byte;
            if (state_q == ST_ADDR_ACK) rd_idx_q <= '0;
            if (state_q == ST_RD_ACK && !bit_din)
                rd_idx_q <= (rd_idx_q == RD_LAST) ? 2'd0 : rd_idx_q + 2'd1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ev_start) begin
            state_d = ST_ADDR;
        end else if (ev_stop) begin
            state_d = ST_IDLE;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_IGNORE:   state_d = ST_IGNORE;
                ST_ADDR:     if (last_bit) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK: begin
                    if (addr_hit)    state_d = rx_byte[0] ? ST_RD_BYTE : ST_CMD_HI;
                    else if (gc_hit) state_d = ST_GC_CMD;
                    else             state_d = ST_IGNORE;
                end
                ST_CMD_HI:   if (last_bit) state_d = ST_HI_ACK;
                ST_HI_ACK:   state_d = ST_CMD_LO;
                ST_CMD_LO:   if (last_bit) state_d = ST_LO_ACK;
                ST_LO_ACK:   state_d = ST_CMD_HI;
                ST_GC_CMD:   if (last_bit) state_d = ST_GC_ACK;
                ST_GC_ACK:   state_d = ST_IGNORE;
                ST_RD_BYTE:  if (last_bit) state_d = ST_RD_ACK;
                ST_RD_ACK:   state_d = bit_din ? ST_IGNORE : ST_RD_BYTE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        shift_en = 1'b0;
        clr      = evt;
        ld_en    = 1'b0;
        ld_dac   = dac_code;
        ld_pd    = pd_bits;
        unique case (state_q)
            ST_ADDR, ST_CMD_HI, ST_CMD_LO, ST_GC_CMD: begin
                shift_en = ack_stb;
            end
            ST_RD_BYTE: begin
                shift_en = ack_stb;
                sda_pull = !tx_bit;
            end
            ST_ADDR_ACK: begin
                sda_pull = addr_hit || gc_hit;
                clr      = clr || bit_stb;
            end
            ST_HI_ACK: begin
                sda_pull = 1'b1;
                clr      = clr || bit_stb;
            end
            ST_LO_ACK: begin
                sda_pull = 1'b1;
                clr      = clr || bit_stb;
                if (ack_stb && hi_q[7:6] == 2'b00) begin
                    ld_en  = 1'b1;
                    ld_dac = {hi_q[HI_W-1:0], rx_byte};
                    ld_pd  = hi_q[5:4];
                end
            end
            ST_GC_ACK: begin
                sda_pull = gc_known;
                clr      = clr || bit_stb;
                if (ack_stb && gc_known) begin
                    ld_en  = 1'b1;
                    ld_pd  = '0;
                    if (rx_byte == GC_RESET) ld_dac = '0;
                end
            end
            ST_RD_ACK: begin
                clr = clr || bit_stb;
            end
            ST_IDLE, ST_IGNORE: begin
                sda_pull = 1'b0;
            end
            default: sda_pull = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2cdac_chk.sv
module i2cdac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_stop,
    input logic        sda_pull,
    input logic        upd_stb,
    input logic [11:0] dac_code,
    input logic [1:0]  pd_bits
);
    p_hold_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> ($stable(dac_code) && $stable(pd_bits)));

    p_event_no_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start || ev_stop) |=> !upd_stb);

    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_pull);

    p_update_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> !sda_pull);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);
endmodule

bind i2cdac_top i2cdac_chk u_chk (.*);

// File: tb/tb_i2cdac_top.sv
module tb_i2cdac_top;
    localparam logic [6:0] ADDR = 7'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 1'b0, ev_stop = 1'b0, bit_stb = 1'b0, bit_din = 1'b1, nv_busy = 1'b0;
    logic        sda_pull, upd_stb;
    logic [11:0] dac_code;
    logic [1:0]  pd_bits;

    always #10 clk = ~clk;

    i2cdac_top #(.DEV_ADDR(ADDR)) dut (.*);

    int checks = 0;
    int errors = 0;

    typedef struct packed { logic [11:0] dac; logic [1:0] pd; } upd_t;
    upd_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop on each update strobe
    always @(negedge clk) begin
        if (rst_n && upd_stb) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected update", {dac_code, pd_bits}, 0);
            end else begin
                upd_t e;
                e = expq.pop_front();
                chk(dac_code == e.dac && pd_bits == e.pd, "R3", "update value",
                    {dac_code, pd_bits}, {e.dac, e.pd});
            end
        end
    end

    task automatic do_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0; @(negedge clk);
    endtask

    task automatic do_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0; @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_din = b; bit_stb = 1'b1; @(negedge clk);
        bit_stb = 1'b0; @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        chk(sda_pull == exp_ack, req, "ack slot", sda_pull, exp_ack);
        send_bit(!sda_pull);
    endtask

    task automatic read_byte(input logic [7:0] exp, input logic nack, input string req);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            got[i] = !sda_pull;
            send_bit(got[i]);
        end
        chk(got == exp, req, "read byte", got, exp);
        chk(sda_pull == 1'b0, req, "master ack slot released", sda_pull, 0);
        send_bit(nack);
    endtask

    task automatic frame(input logic [1:0] code, input logic [1:0] pd,
                         input logic [11:0] dac, input bit applied, input string req);
        write_byte({code, pd, dac[11:8]}, 1'b1, req);
        if (applied) expq.push_back({dac, pd});
        write_byte(dac[7:0], 1'b1, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sda_pull == 0 && upd_stb == 0, "R1", "reset outputs", {sda_pull, upd_stb}, 0);
        chk(dac_code == 0 && pd_bits == 0, "R1", "reset regs", {dac_code, pd_bits}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R3: single write
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R2");
        frame(2'b00, 2'b00, 12'hABC, 1, "R3");
        do_stop();
        chk(dac_code == 12'hABC, "R3", "dac after write", dac_code, 12'hABC);

        // R4: continuous frames, C0 position set in one (ignored)
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R4");
        frame(2'b00, 2'b01, 12'h123, 1, "R4");
        frame(2'b00, 2'b10, 12'hFFF, 1, "R4");
        frame(2'b00, 2'b00, 12'h000, 1, "R4");
        do_stop();
        chk(dac_code == 12'h000 && pd_bits == 0, "R4", "after continuous", {dac_code, pd_bits}, 0);

        // R9: write while busy, R7 status shows busy
        nv_busy = 1'b1;
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R9");
        frame(2'b00, 2'b11, 12'h5A5, 1, "R9");
        do_stop();
        chk(dac_code == 12'h5A5 && pd_bits == 2'b11, "R9", "busy write", {dac_code, pd_bits}, {12'h5A5, 2'b11});
        do_start();
        write_byte({ADDR, 1'b1}, 1'b1, "R7");
        read_byte(8'h03, 1'b1, "R7");
        do_stop();
        nv_busy = 1'b0;

        // R7: read loop and NACK
        do_start();
        write_byte({ADDR, 1'b1}, 1'b1, "R2");
        read_byte(8'h83, 1'b0, "R7");
        read_byte(8'h05, 1'b0, "R7");
        read_byte(8'hA5, 1'b0, "R7");
        read_byte(8'h83, 1'b1, "R7");
        chk(sda_pull == 1'b0, "R7", "released after nack", sda_pull, 0);
        for (int i = 0; i < 8; i++) begin
            chk(sda_pull == 1'b0, "R7", "no drive after nack", sda_pull, 0);
            send_bit(1'b0);
        end
        do_stop();

        // R5: stop mid second byte, then restart mid second byte
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R5");
        write_byte(8'h13, 1'b1, "R5");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_stop();
        chk(dac_code == 12'h5A5 && pd_bits == 2'b11, "R5", "stop abort", {dac_code, pd_bits}, {12'h5A5, 2'b11});
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R5");
        write_byte(8'h02, 1'b1, "R5");
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        do_start();
        chk(dac_code == 12'h5A5, "R5", "restart abort", dac_code, 12'h5A5);
        write_byte({ADDR, 1'b0}, 1'b1, "R5");
        frame(2'b00, 2'b00, 12'h777, 1, "R5");
        do_stop();

        // R6: reserved codes acked, no change
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R6");
        frame(2'b01, 2'b11, 12'h111, 0, "R6");
        frame(2'b10, 2'b01, 12'h222, 0, "R6");
        frame(2'b11, 2'b10, 12'h333, 0, "R6");
        do_stop();
        chk(dac_code == 12'h777 && pd_bits == 0, "R6", "reserved no change", {dac_code, pd_bits}, {12'h777, 2'b00});

        // R2: foreign address ignored
        do_start();
        write_byte({7'h61, 1'b0}, 1'b0, "R2");
        write_byte(8'h0A, 1'b0, "R2");
        write_byte(8'hBC, 1'b0, "R2");
        do_stop();
        chk(dac_code == 12'h777, "R2", "foreign no change", dac_code, 12'h777);

        // R8: general call
        do_start();
        write_byte({ADDR, 1'b0}, 1'b1, "R8");
        frame(2'b00, 2'b10, 12'h321, 1, "R8");
        do_stop();
        do_start();
        write_byte(8'h00, 1'b1, "R8");
        expq.push_back({12'h321, 2'b00});
        write_byte(8'h09, 1'b1, "R8");
        do_stop();
        do_start();
        write_byte(8'h00, 1'b1, "R8");
        write_byte(8'h55, 1'b0, "R8");
        do_stop();
        chk(dac_code == 12'h321 && pd_bits == 0, "R8", "unknown gc", {dac_code, pd_bits}, {12'h321, 2'b00});
        do_start();
        write_byte(8'h00, 1'b1, "R8");
        expq.push_back({12'h000, 2'b00});
        write_byte(8'h06, 1'b1, "R8");
        do_stop();
        chk(dac_code == 0 && pd_bits == 0, "R8", "gc reset", {dac_code, pd_bits}, 0);

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R10", "pending updates", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule